// File: doc/BRIEF.md
# CAN Receive Frame Queue with Interrupt-Driven Pop

This block queues received CAN frames for the CPU. Each accepted frame arrives as four 32-bit words: identifier, control (length code, extended and remote bits), and two payload words. It is stored in a small circular buffer that holds up to six entries. The CPU never handles pointers. It always reads the oldest pending frame from one fixed output window. It tells the queue that it has consumed that frame by clearing the frame-available interrupt flag. That clear is the pop strobe.

Three interrupt flags come out of the block. Frame-available follows the occupancy and is high whenever at least one frame is waiting. Warning is sticky and is set when the queue fills to its watermark of five frames. Overflow is sticky and is set when a frame arrives while all six slots are taken. That frame is dropped. Both sticky flags are cleared with write-one-to-clear strobes. A queue-enable input gates the whole function. While it is low, the queue is flushed, every flag reads zero and incoming frames are ignored. Acceptance filtering and the bus receive path sit outside this block.

Top module: `canrx_fifo`

## Requirements
- R1: While `fifo_en` is 0, which is also the state after reset, all three interrupt flags read 0, writes are ignored and the queue is emptied. A frame offered while disabled never reaches the window.
- R2: The queue holds six frames. After six writes and no pops, all six frames are delivered in turn.
- R3: The window ports always present the oldest unconsumed frame, with its identifier, control and both data words, in arrival order.
- R4: A write into an empty queue sets `irq_avail` and loads the frame into the window on the same clock edge that accepts it.
- R5: A one-cycle `clr_avail` pulse while `irq_avail` is 1 removes the window frame. On the next edge the following frame appears and `irq_avail` stays 1. If no frame is left, `irq_avail` falls to 0.
- R6: A write while six frames are held and no pop occurs is discarded and sets `irq_ovf`. The discarded frame never appears in the window.
- R7: `irq_warn` is set on the edge where the occupancy goes from four to five, and stays set.
- R8: A `clr_avail` pulse while the queue is empty has no effect. A later write still appears in the window as the sole frame.
- R9: `irq_warn` and `irq_ovf` remain set until a one-cycle pulse on `clr_warn` or `clr_ovf` respectively, which clears them on the next edge.
- R10: A write and a pop in the same cycle are both performed and the occupancy is unchanged. The window advances, and the written frame is queued behind the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | Queue enable; 0 flushes the queue and holds flags clear |
| wr_valid | input | 1 | One-cycle strobe: an accepted frame is present on the write words |
| wr_id | input | 32 | Identifier word of the incoming frame |
| wr_ctrl | input | 32 | Control word of the incoming frame |
| wr_data0 | input | 32 | First payload word of the incoming frame |
| wr_data1 | input | 32 | Second payload word of the incoming frame |
| clr_avail | input | 1 | Write-one-to-clear of the available flag; pops the window frame |
| clr_warn | input | 1 | Write-one-to-clear of the warning flag |
| clr_ovf | input | 1 | Write-one-to-clear of the overflow flag |
| win_id | output | 32 | Identifier word of the oldest frame |
| win_ctrl | output | 32 | Control word of the oldest frame |
| win_data0 | output | 32 | First payload word of the oldest frame |
| win_data1 | output | 32 | Second payload word of the oldest frame |
| irq_avail | output | 1 | Frame-available interrupt flag |
| irq_warn | output | 1 | Watermark warning interrupt flag (sticky) |
| irq_ovf | output | 1 | Overflow interrupt flag (sticky) |

## Verification
The bench fills the queue to its limit and then offers a seventh frame. A design with an off-by-one full test would either overwrite the oldest entry, which shows up as a corrupted or reordered window, or fail to raise the overflow flag. It also pops while the queue is empty and then writes. A design that lets an empty pop move the read pointer would show a stale frame or a dropped flag. The bench writes and pops in the same cycle at four frames and then adds one more. A design that lets either side win would raise the watermark warning too early or too late, or lose the simultaneous frame from the sequence. Disabling the queue with frames inside must leave no flag and no frame behind, and a design that only masks the flags would reveal old frames after re-enable.

// File: rtl/canrx_fifo_pkg.sv
package canrx_fifo_pkg;

  parameter int WORD_W = 32;

  typedef struct packed {
    logic [WORD_W-1:0] id;
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] d0;
    logic [WORD_W-1:0] d1;
  } rx_frame_t;

endpackage

// File: rtl/canrx_fifo_ctrl.sv
module canrx_fifo_ctrl #(
  parameter int DEPTH = 6
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en,
  input  logic                             push_req,
  input  logic                             pop_req,
  output logic                             push_ok,
  output logic                             pop_ok,
  output logic [$clog2(DEPTH)-1:0]         wr_ptr,
  output logic [$clog2(DEPTH)-1:0]         rd_ptr,
  output logic [$clog2(DEPTH)-1:0]         rd_next,
  output logic [$clog2(DEPTH+1)-1:0]       count,
  output logic [$clog2(DEPTH+1)-1:0]       count_nxt
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  // a pop needs a stored frame; a push needs a free slot or a pop alongside
  always_comb begin
    pop_ok  = en && pop_req && (count != '0);
    push_ok = en && push_req && ((count != FULL_CNT) || pop_ok);
    rd_next = bump(rd_ptr);
    case ({push_ok, pop_ok})
      2'b10:   count_nxt = count + ONE_CNT;
      2'b01:   count_nxt = count - ONE_CNT;
      default: count_nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= rd_next;
      count <= count_nxt;
    end
  end

endmodule

// File: rtl/canrx_fifo_store.sv
module canrx_fifo_store
  import canrx_fifo_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push_ok,
  input  logic                       pop_ok,
  input  logic [$clog2(DEPTH)-1:0]   wr_ptr,
  input  logic [$clog2(DEPTH)-1:0]   rd_next,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  rx_frame_t                  wr_frame,
  output rx_frame_t                  win
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  rx_frame_t mem [DEPTH];
  logic      load_mem;
  logic      load_wr;

  // window source: the stored successor, or the incoming frame when it
  // becomes the oldest one (empty queue, or last frame popped as it arrives)
  always_comb begin
    load_mem = pop_ok && (count > ONE_CNT);
    load_wr  = push_ok && ((count == '0) || (pop_ok && (count == ONE_CNT)));
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_frame;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win <= '0;
    end else if (load_mem) begin
      win <= mem[rd_next];
    end else if (load_wr) begin
      win <= wr_frame;
    end
  end

endmodule

// File: rtl/canrx_fifo_flags.sv
module canrx_fifo_flags #(
  parameter int DEPTH      = 6,
  parameter int WARN_LEVEL = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic [$clog2(DEPTH+1)-1:0] count_nxt,
  input  logic                       push_req,
  input  logic                       push_ok,
  input  logic                       clr_warn,
  input  logic                       clr_ovf,
  output logic                       irq_avail,
  output logic                       irq_warn,
  output logic                       irq_ovf
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] WARN_CNT = CNT_W'(WARN_LEVEL);
  localparam logic [CNT_W-1:0] PRE_WARN = CNT_W'(WARN_LEVEL - 1);

  logic warn_hit;
  logic ovf_hit;

  always_comb begin
    warn_hit = (count == PRE_WARN) && (count_nxt == WARN_CNT);
    ovf_hit  = en && push_req && !push_ok;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      irq_avail <= 1'b0;
      irq_warn  <= 1'b0;
      irq_ovf   <= 1'b0;
    end else begin
      irq_avail <= (count_nxt != '0);
      if (warn_hit)      irq_warn <= 1'b1;
      else if (clr_warn) irq_warn <= 1'b0;
      if (ovf_hit)       irq_ovf  <= 1'b1;
      else if (clr_ovf)  irq_ovf  <= 1'b0;
    end
  end

endmodule

// File: rtl/canrx_fifo.sv
module canrx_fifo
  import canrx_fifo_pkg::*;
#(
  parameter int DEPTH      = 6,
  parameter int WARN_LEVEL = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_id,
  input  logic [WORD_W-1:0] wr_ctrl,
  input  logic [WORD_W-1:0] wr_data0,
  input  logic [WORD_W-1:0] wr_data1,
  input  logic              clr_avail,
  input  logic              clr_warn,
  input  logic              clr_ovf,
  output logic [WORD_W-1:0] win_id,
  output logic [WORD_W-1:0] win_ctrl,
  output logic [WORD_W-1:0] win_data0,
  output logic [WORD_W-1:0] win_data1,
  output logic              irq_avail,
  output logic              irq_warn,
  output logic              irq_ovf
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             push_ok;
  logic             pop_ok;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] rd_next;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] count_nxt;
  rx_frame_t        wr_frame;
  rx_frame_t        win;

  always_comb begin
    wr_frame.id   = wr_id;
    wr_frame.ctrl = wr_ctrl;
    wr_frame.d0   = wr_data0;
    wr_frame.d1   = wr_data1;
    win_id    = win.id;
    win_ctrl  = win.ctrl;
    win_data0 = win.d0;
    win_data1 = win.d1;
  end

  // clearing the available flag is the pop request
  canrx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .en        (fifo_en),
    .push_req  (wr_valid),
    .pop_req   (clr_avail),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .rd_next   (rd_next),
    .count     (count),
    .count_nxt (count_nxt)
  );

  canrx_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .wr_ptr   (wr_ptr),
    .rd_next  (rd_next),
    .count    (count),
    .wr_frame (wr_frame),
    .win      (win)
  );

  canrx_fifo_flags #(.DEPTH(DEPTH), .WARN_LEVEL(WARN_LEVEL)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .en        (fifo_en),
    .count     (count),
    .count_nxt (count_nxt),
    .push_req  (wr_valid),
    .push_ok   (push_ok),
    .clr_warn  (clr_warn),
    .clr_ovf   (clr_ovf),
    .irq_avail (irq_avail),
    .irq_warn  (irq_warn),
    .irq_ovf   (irq_ovf)
  );

endmodule

// File: rtl/canrx_fifo_chk.sv
module canrx_fifo_chk #(
  parameter int DEPTH      = 6,
  parameter int WARN_LEVEL = 5
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       fifo_en,
  input logic                       wr_valid,
  input logic                       clr_avail,
  input logic                       push_ok,
  input logic                       pop_ok,
  input logic [$clog2(DEPTH)-1:0]   wr_ptr,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       irq_avail,
  input logic                       irq_warn,
  input logic                       irq_ovf
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] PRE_WARN = CNT_W'(WARN_LEVEL - 1);

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> (!irq_avail && !irq_warn && !irq_ovf)); // R1

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT); // R2

  AST_AVAIL_ON_FILL: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && wr_valid && count == '0) |=> irq_avail); // R4

  AST_OVF_RAISE: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && wr_valid && !clr_avail && count == FULL_CNT) |=> irq_ovf); // R6

  AST_OVF_DROP: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && wr_valid && !clr_avail && count == FULL_CNT) |=> $stable(wr_ptr)); // R6

  AST_WARN_RAISE: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && count == PRE_WARN && wr_valid && !clr_avail) |=> irq_warn); // R7

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (!irq_avail && clr_avail && !wr_valid) |=> !irq_avail); // R8

  AST_PUSH_POP_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && push_ok && pop_ok) |=> $stable(count)); // R10

endmodule

bind canrx_fifo canrx_fifo_chk #(.DEPTH(DEPTH), .WARN_LEVEL(WARN_LEVEL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fifo_en   (fifo_en),
  .wr_valid  (wr_valid),
  .clr_avail (clr_avail),
  .push_ok   (push_ok),
  .pop_ok    (pop_ok),
  .wr_ptr    (wr_ptr),
  .count     (count),
  .irq_avail (irq_avail),
  .irq_warn  (irq_warn),
  .irq_ovf   (irq_ovf)
);

// File: tb/canrx_fifo_test.sv
module canrx_fifo_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fifo_en = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_id = '0, wr_ctrl = '0, wr_data0 = '0, wr_data1 = '0;
  logic        clr_avail = 1'b0, clr_warn = 1'b0, clr_ovf = 1'b0;
  logic [31:0] win_id, win_ctrl, win_data0, win_data1;
  logic        irq_avail, irq_warn, irq_ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  canrx_fifo uut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .wr_valid(wr_valid),
    .wr_id(wr_id), .wr_ctrl(wr_ctrl), .wr_data0(wr_data0), .wr_data1(wr_data1),
    .clr_avail(clr_avail), .clr_warn(clr_warn), .clr_ovf(clr_ovf),
    .win_id(win_id), .win_ctrl(win_ctrl), .win_data0(win_data0), .win_data1(win_data1),
    .irq_avail(irq_avail), .irq_warn(irq_warn), .irq_ovf(irq_ovf)
  );

  function automatic logic [127:0] frame(input int k);
    return {32'h1000_0000 + k, 32'h0000_0800 + k, 32'hA5A5_0000 + k, 32'h5A5A_0000 + k};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_win(input string req, input int k);
    check(req, {win_id, win_ctrl, win_data0, win_data1}, frame(k));
  endtask

  task automatic check_flags(input string req, input logic a, input logic w, input logic o);
    check(req, {125'd0, irq_avail, irq_warn, irq_ovf}, {125'd0, a, w, o});
  endtask

  // drive at negedge; the next posedge acts; caller samples at the following negedge
  task automatic cycle(input bit push, input bit pop, input int k);
    {wr_id, wr_ctrl, wr_data0, wr_data1} = frame(k);
    wr_valid  = push;
    clr_avail = pop;
    @(negedge clk);
    wr_valid  = 1'b0;
    clr_avail = 1'b0;
  endtask

  task automatic pulse_clr(input bit w, input bit o);
    clr_warn = w;
    clr_ovf  = o;
    @(negedge clk);
    clr_warn = 1'b0;
    clr_ovf  = 1'b0;
  endtask

  task automatic t_reset_disabled();
    check_flags("R1 reset flags", 1'b0, 1'b0, 1'b0);
    cycle(1'b1, 1'b0, 90);
    check_flags("R1 write while disabled", 1'b0, 1'b0, 1'b0);
    fifo_en = 1'b1;
    @(negedge clk);
    check_flags("R1 disabled write not queued", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_order_and_warn();
    cycle(1'b1, 1'b0, 0);
    check_flags("R4 avail on first write", 1'b1, 1'b0, 1'b0);
    check_win("R4 window on first write", 0);
    for (int i = 1; i < 4; i++) cycle(1'b1, 1'b0, i);
    check_flags("R7 no warn at four", 1'b1, 1'b0, 1'b0);
    cycle(1'b1, 1'b0, 4);
    check_flags("R7 warn at five", 1'b1, 1'b1, 1'b0);
    cycle(1'b1, 1'b0, 5);
    check_flags("R2 six held no overflow", 1'b1, 1'b1, 1'b0);
    check_win("R3 oldest still shown", 0);
    for (int i = 1; i < 6; i++) begin
      cycle(1'b0, 1'b1, 0);
      check_win("R3 R5 next frame after pop", i);
      check_flags("R5 avail stays with frames left", 1'b1, 1'b1, 1'b0);
    end
    cycle(1'b0, 1'b1, 0);
    check_flags("R5 avail drops after last pop, R9 warn sticky", 1'b0, 1'b1, 1'b0);
    pulse_clr(1'b1, 1'b0);
    check_flags("R9 warn cleared", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_overflow();
    for (int i = 10; i < 16; i++) cycle(1'b1, 1'b0, i);
    cycle(1'b1, 1'b0, 16);
    check_flags("R6 overflow raised", 1'b1, 1'b1, 1'b1);
    check_win("R6 window unchanged", 10);
    for (int i = 11; i < 16; i++) begin
      cycle(1'b0, 1'b1, 0);
      check_win("R6 order kept after drop", i);
    end
    cycle(1'b0, 1'b1, 0);
    check_flags("R6 dropped frame never queued, R9 ovf sticky", 1'b0, 1'b1, 1'b1);
    pulse_clr(1'b1, 1'b1);
    check_flags("R9 both cleared", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_empty_pop();
    cycle(1'b0, 1'b1, 0);
    check_flags("R8 empty pop no effect", 1'b0, 1'b0, 1'b0);
    cycle(1'b1, 1'b0, 20);
    check_win("R8 write after empty pop", 20);
    check_flags("R8 avail after write", 1'b1, 1'b0, 1'b0);
    cycle(1'b0, 1'b1, 0);
    check_flags("R8 single frame popped", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_push_pop_same();
    for (int i = 30; i < 34; i++) cycle(1'b1, 1'b0, i);
    cycle(1'b1, 1'b1, 34);
    check_win("R10 window advanced", 31);
    check_flags("R10 level unchanged no warn", 1'b1, 1'b0, 1'b0);
    cycle(1'b1, 1'b0, 35);
    check_flags("R10 R7 fifth frame warns", 1'b1, 1'b1, 1'b0);
    for (int i = 32; i < 36; i++) begin
      cycle(1'b0, 1'b1, 0);
      check_win("R10 simultaneous frame in order", i);
    end
    cycle(1'b0, 1'b1, 0);
    check_flags("R10 drained", 1'b0, 1'b1, 1'b0);
    pulse_clr(1'b1, 1'b0);
  endtask

  task automatic t_flush();
    for (int i = 40; i < 43; i++) cycle(1'b1, 1'b0, i);
    fifo_en = 1'b0;
    @(negedge clk);
    check_flags("R1 disable clears avail", 1'b0, 1'b0, 1'b0);
    fifo_en = 1'b1;
    @(negedge clk);
    check_flags("R1 queue flushed", 1'b0, 1'b0, 1'b0);
    cycle(1'b1, 1'b0, 50);
    check_win("R1 fresh frame after flush", 50);
    cycle(1'b0, 1'b1, 0);
    check_flags("R1 only one frame after flush", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_disabled();
    t_order_and_warn();
    t_overflow();
    t_empty_pop();
    t_push_pop_same();
    t_flush();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule